// File: doc/BRIEF.md
# Filtered Performance Event Counter Bank

This block holds a bank of six general event counters and three fixed event counters, each 48 bits wide. Every general counter takes a 4-bit count of event occurrences each cycle. A per-counter configuration word turns that count into an increment. The count first passes a privilege gate. It then goes through a threshold compare, an optional inversion and an optional rising-edge detector. Each fixed counter is tied to its own one-bit event line and adds one on every cycle that line is high, subject only to the privilege gate.

Software programs and observes the bank through a simple register port. A write port applies on the clock edge. A read port is combinational. Both address counter values, configuration words and two write-one-to-clear status words. One status word holds the overflow bits, which set when a counter wraps. The other holds the configuration-error bits, which set when edge detection is selected with a zero threshold. Both status words are also driven straight out as ports.

Register map (5-bit address): general values at 0..5, general configurations at 8..13, fixed values at 16..18, the shared fixed configuration at 20, overflow status at 24, configuration-error status at 25.

Top module: `pmc_bank`

## Requirements
- R1: After reset every counter, configuration word, overflow bit and configuration-error bit reads as zero.
- R2: A general counter that is enabled with threshold 0 adds its raw 4-bit occurrence count each cycle. General counter i takes its count from `evt_cnt_i[4*i+3:4*i]`. General configuration bits are: bit 0 enable, bit 1 user enable, bit 2 kernel enable, bit 3 invert, bit 4 edge, bits 15:8 threshold. Each counter uses only its own slice.
- R3: A counter advances at privilege level 0 only when its kernel enable bit is set. It advances at privilege levels 1, 2 and 3 only when its user enable bit is set.
- R4: With a nonzero threshold, a general counter adds one on each cycle whose occurrence count is greater than or equal to the threshold.
- R5: With a nonzero threshold and the invert bit set, a general counter adds one on each cycle whose occurrence count is below the threshold.
- R6: With a nonzero threshold and the edge bit set, a general counter adds one only on a cycle that qualifies when the cycle before did not.
- R7: Edge mode with threshold 0 never counts. It sets the counter's configuration-error bit (bit i of address 25 and of `cfg_err_o`). That bit stays set until a 1 is written to it while the bad setting is no longer active.
- R8: A counter value write is visible on the next cycle and wins over an increment in the same cycle. A configuration word reads back with the fields that were written.
- R9: A counter that wraps past 2^48-1 keeps the low 48 bits of the sum and sets its overflow bit. That bit is bit i of address 24 for a general counter and bit 8+j for a fixed counter, and is also on `ovf_o`. The bit stays set until a 1 is written to it.
- R10: Fixed counter j adds one per cycle while `fix_evt_i[j]` is high, its enable bit is set and the privilege gate allows it. Its enable, user enable and kernel enable are bits 4j, 4j+1 and 4j+2 of address 20.
- R11: The edge detector's remembered state returns to non-qualifying whenever its counter is disabled or its configuration is written. A steady qualifying input therefore counts again once the counter is re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| priv_lvl_i | input | 2 | Current privilege level (0 = kernel) |
| evt_cnt_i | input | 24 | Per-cycle occurrence counts, 4 bits per general counter |
| fix_evt_i | input | 3 | Dedicated event lines of the fixed counters |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register write address |
| wr_data_i | input | 64 | Register write data |
| rd_addr_i | input | 5 | Register read address |
| rd_data_o | output | 64 | Register read data (combinational) |
| ovf_o | output | 9 | Overflow bits: general 0..5, fixed 6..8 |
| cfg_err_o | output | 6 | Configuration-error bits of the general counters |

## Verification
Every effect the bench looks for lands on the first rising edge after the cycle that causes it. An event count, a value write, a configuration write or a status clear presented in one cycle is therefore visible at the read port from the following falling edge. The edge detector and the privilege gate act in that same cycle, with no extra pipeline stage. The bench drives inputs at falling edges. Its scoreboard monitor reads each expected register in the half cycle before the next rising edge, so no counter moves while a batch of expected items is compared.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    parameter int PMC_NUM_GEN = 6;
    parameter int PMC_NUM_FIX = 3;
    parameter int PMC_CNT_W   = 48;
    parameter int PMC_EVT_W   = 4;
    parameter int PMC_THR_W   = 8;
    parameter int PMC_DATA_W  = 64;
    parameter int PMC_ADDR_W  = 5;

    // register map
    localparam int A_GEN_VAL   = 0;
    localparam int A_GEN_CFG   = 8;
    localparam int A_FIX_VAL   = 16;
    localparam int A_FIX_CFG   = 20;
    localparam int A_OVF       = 24;
    localparam int A_ERR       = 25;
    localparam int OVF_FIX_OFF = 8;
    localparam int FIX_CFG_STRIDE = 4;

    // general counter configuration word fields
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_USER_BIT = 1;
    localparam int CFG_KERN_BIT = 2;
    localparam int CFG_INV_BIT  = 3;
    localparam int CFG_EDGE_BIT = 4;
    localparam int CFG_THR_LSB  = 8;

    typedef struct packed {
        logic [PMC_THR_W-1:0] thr;
        logic                 edge_en;
        logic                 inv;
        logic                 kern;
        logic                 user;
        logic                 en;
    } gen_cfg_t;

    typedef struct packed {
        logic kern;
        logic user;
        logic en;
    } fix_cfg_t;

    function automatic logic priv_allows(input logic [1:0] lvl,
                                         input logic user, input logic kern);
        return (lvl == 2'd0) ? kern : user;
    endfunction

endpackage

// File: rtl/pmc_qualifier.sv
module pmc_qualifier
    import pmc_pkg::*;
#(
    parameter int EVT_W = PMC_EVT_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  gen_cfg_t         cfg_i,
    input  logic             cfg_wr_i,
    input  logic [EVT_W-1:0] evt_cnt_i,
    input  logic [1:0]       priv_lvl_i,
    output logic [EVT_W-1:0] inc_o,
    output logic             bad_cfg_o
);

    localparam int CMP_W = (EVT_W > PMC_THR_W) ? EVT_W : PMC_THR_W;

    typedef struct packed {
        logic prev;
    } qual_state_t;

    qual_state_t s_d, s_q;
    logic             gate_ok;
    logic             meets;
    logic             cond;
    logic [EVT_W-1:0] base_inc;

    always_comb begin
        s_d       = s_q;
        gate_ok   = cfg_i.en && priv_allows(priv_lvl_i, cfg_i.user, cfg_i.kern);
        meets     = CMP_W'(evt_cnt_i) >= CMP_W'(cfg_i.thr);
        cond      = meets ^ cfg_i.inv;
        bad_cfg_o = cfg_i.en && cfg_i.edge_en && (cfg_i.thr == '0);

        if (cfg_i.thr == '0) begin
            base_inc = cfg_i.edge_en ? '0 : evt_cnt_i;
        end else if (cfg_i.edge_en) begin
            base_inc = (cond && !s_q.prev) ? EVT_W'(1) : '0;
        end else begin
            base_inc = cond ? EVT_W'(1) : '0;
        end

        inc_o = gate_ok ? base_inc : '0;

        if (!cfg_i.en || cfg_wr_i || (cfg_i.thr == '0)) begin
            s_d.prev = 1'b0;
        end else begin
            s_d.prev = cond;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // privilege gate blocks every increment
    assert_priv_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !priv_allows(priv_lvl_i, cfg_i.user, cfg_i.kern) |-> (inc_o == '0));

    // edge mode with a zero threshold never counts
    assert_edge_thr0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.edge_en && cfg_i.thr == '0) |-> (inc_o == '0));

    // edge mode adds at most one, and never twice in a row
    assert_edge_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.edge_en && cfg_i.thr != '0) |-> (inc_o <= EVT_W'(1)));

    assert_edge_no_repeat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.edge_en && cfg_i.thr != '0 && inc_o != '0 && !cfg_wr_i)
            |=> (!cfg_i.edge_en || cfg_i.thr == '0 || inc_o == '0 || $past(cfg_wr_i)));

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] val_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t     s_d, s_q;
    logic [CNT_W:0] sum;
    logic           wrap;

    always_comb begin
        s_d   = s_q;
        sum   = {1'b0, s_q.val} + (CNT_W + 1)'(inc_i);
        wrap  = !wr_i && sum[CNT_W];
        s_d.val = wr_i ? wdata_i : sum[CNT_W-1:0];
        s_d.ovf = wrap || (s_q.ovf && !ovf_clr_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign val_o = s_q.val;
    assign ovf_o = s_q.ovf;

    assert_write_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (val_o == $past(wdata_i)));

    assert_hold_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && inc_i == '0) |=> (val_o == $past(val_o)));

    assert_ovf_on_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> (!$past(wr_i) && (val_o < $past(val_o))));

endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_GEN = PMC_NUM_GEN,
    parameter int NUM_FIX = PMC_NUM_FIX,
    parameter int CNT_W   = PMC_CNT_W,
    parameter int EVT_W   = PMC_EVT_W,
    parameter int DATA_W  = PMC_DATA_W,
    parameter int ADDR_W  = PMC_ADDR_W
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [1:0]               priv_lvl_i,
    input  logic [NUM_GEN*EVT_W-1:0] evt_cnt_i,
    input  logic [NUM_FIX-1:0]       fix_evt_i,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [DATA_W-1:0]        wr_data_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic [NUM_GEN+NUM_FIX-1:0] ovf_o,
    output logic [NUM_GEN-1:0]       cfg_err_o
);

    localparam int NUM_ALL = NUM_GEN + NUM_FIX;

    typedef struct packed {
        gen_cfg_t [NUM_GEN-1:0] gcfg;
        fix_cfg_t [NUM_FIX-1:0] fcfg;
        logic     [NUM_GEN-1:0] err;
    } bank_state_t;

    bank_state_t s_d, s_q;

    logic [NUM_GEN-1:0] gen_val_wr, gen_cfg_wr, gen_bad, gen_ovf, gen_ovf_clr;
    logic [NUM_FIX-1:0] fix_val_wr, fix_ovf, fix_ovf_clr, fix_hit;
    logic               fix_cfg_wr, ovf_wr, err_wr;
    logic [EVT_W-1:0]   gen_inc [NUM_GEN];
    logic [CNT_W-1:0]   gen_val [NUM_GEN];
    logic [CNT_W-1:0]   fix_val [NUM_FIX];
    logic               unused_wdata;

    assign unused_wdata = ^wr_data_i[DATA_W-1:CNT_W];

    // write decode
    always_comb begin
        fix_cfg_wr = wr_en_i && (wr_addr_i == ADDR_W'(A_FIX_CFG));
        ovf_wr     = wr_en_i && (wr_addr_i == ADDR_W'(A_OVF));
        err_wr     = wr_en_i && (wr_addr_i == ADDR_W'(A_ERR));
        for (int i = 0; i < NUM_GEN; i++) begin
            gen_val_wr[i]  = wr_en_i && (wr_addr_i == ADDR_W'(A_GEN_VAL + i));
            gen_cfg_wr[i]  = wr_en_i && (wr_addr_i == ADDR_W'(A_GEN_CFG + i));
            gen_ovf_clr[i] = ovf_wr && wr_data_i[i];
        end
        for (int j = 0; j < NUM_FIX; j++) begin
            fix_val_wr[j]  = wr_en_i && (wr_addr_i == ADDR_W'(A_FIX_VAL + j));
            fix_ovf_clr[j] = ovf_wr && wr_data_i[OVF_FIX_OFF + j];
            fix_hit[j]     = fix_evt_i[j] && s_q.fcfg[j].en &&
                             priv_allows(priv_lvl_i, s_q.fcfg[j].user, s_q.fcfg[j].kern);
        end
    end

    // configuration and status next state
    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (gen_cfg_wr[i]) begin
                s_d.gcfg[i].en      = wr_data_i[CFG_EN_BIT];
                s_d.gcfg[i].user    = wr_data_i[CFG_USER_BIT];
                s_d.gcfg[i].kern    = wr_data_i[CFG_KERN_BIT];
                s_d.gcfg[i].inv     = wr_data_i[CFG_INV_BIT];
                s_d.gcfg[i].edge_en = wr_data_i[CFG_EDGE_BIT];
                s_d.gcfg[i].thr     = wr_data_i[CFG_THR_LSB +: PMC_THR_W];
            end
            s_d.err[i] = gen_bad[i] || (s_q.err[i] && !(err_wr && wr_data_i[i]));
        end
        if (fix_cfg_wr) begin
            for (int j = 0; j < NUM_FIX; j++) begin
                s_d.fcfg[j] = wr_data_i[FIX_CFG_STRIDE*j +: 3];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // general counters
    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        pmc_qualifier #(.EVT_W(EVT_W)) u_qual (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .cfg_i      (s_q.gcfg[g]),
            .cfg_wr_i   (gen_cfg_wr[g]),
            .evt_cnt_i  (evt_cnt_i[g*EVT_W +: EVT_W]),
            .priv_lvl_i (priv_lvl_i),
            .inc_o      (gen_inc[g]),
            .bad_cfg_o  (gen_bad[g])
        );
        pmc_counter #(.CNT_W(CNT_W), .INC_W(EVT_W)) u_cnt (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_i      (gen_val_wr[g]),
            .wdata_i   (wr_data_i[CNT_W-1:0]),
            .inc_i     (gen_inc[g]),
            .ovf_clr_i (gen_ovf_clr[g]),
            .val_o     (gen_val[g]),
            .ovf_o     (gen_ovf[g])
        );

        assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cfg_err_o[g] && !(err_wr && wr_data_i[g])) |=> cfg_err_o[g]);
    end

    // fixed counters
    for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
        pmc_counter #(.CNT_W(CNT_W), .INC_W(1)) u_cnt (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_i      (fix_val_wr[f]),
            .wdata_i   (wr_data_i[CNT_W-1:0]),
            .inc_i     (fix_hit[f]),
            .ovf_clr_i (fix_ovf_clr[f]),
            .val_o     (fix_val[f]),
            .ovf_o     (fix_ovf[f])
        );

        assert_fix_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!fix_evt_i[f] && !fix_val_wr[f]) |=> (fix_val[f] == $past(fix_val[f])));
    end

    // read mux
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_GEN; i++) begin
            if (rd_addr_i == ADDR_W'(A_GEN_VAL + i)) rd_data_o = DATA_W'(gen_val[i]);
            if (rd_addr_i == ADDR_W'(A_GEN_CFG + i)) begin
                rd_data_o[CFG_EN_BIT]                  = s_q.gcfg[i].en;
                rd_data_o[CFG_USER_BIT]                = s_q.gcfg[i].user;
                rd_data_o[CFG_KERN_BIT]                = s_q.gcfg[i].kern;
                rd_data_o[CFG_INV_BIT]                 = s_q.gcfg[i].inv;
                rd_data_o[CFG_EDGE_BIT]                = s_q.gcfg[i].edge_en;
                rd_data_o[CFG_THR_LSB +: PMC_THR_W]    = s_q.gcfg[i].thr;
            end
            if (rd_addr_i == ADDR_W'(A_OVF)) rd_data_o[i] = gen_ovf[i];
            if (rd_addr_i == ADDR_W'(A_ERR)) rd_data_o[i] = s_q.err[i];
        end
        for (int j = 0; j < NUM_FIX; j++) begin
            if (rd_addr_i == ADDR_W'(A_FIX_VAL + j)) rd_data_o = DATA_W'(fix_val[j]);
            if (rd_addr_i == ADDR_W'(A_FIX_CFG))
                rd_data_o[FIX_CFG_STRIDE*j +: 3] = s_q.fcfg[j];
            if (rd_addr_i == ADDR_W'(A_OVF)) rd_data_o[OVF_FIX_OFF + j] = fix_ovf[j];
        end
    end

    assign cfg_err_o = s_q.err;
    assign ovf_o     = NUM_ALL'({fix_ovf, gen_ovf});

endmodule

// File: tb/pmc_bank_tb.sv
module pmc_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 6;
    localparam int NF = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        priv = 2'd0;
    logic [NG*4-1:0]   evt = '0;
    logic [NF-1:0]     fevt = '0;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [63:0]       wr_data = '0;
    logic [4:0]        rd_addr = '0;
    logic [63:0]       rd_data;
    logic [NG+NF-1:0]  ovf;
    logic [NG-1:0]     cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    int pushed = 0;
    int done = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [4:0]  addr;
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_bank dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .priv_lvl_i (priv),
        .evt_cnt_i  (evt),
        .fix_evt_i  (fevt),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .ovf_o      (ovf),
        .cfg_err_o  (cfg_err)
    );

    task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items and compares read data
    initial begin
        sb_item_t it;
        forever begin
            wait (pushed != done);
            it = sb.pop_front();
            rd_addr = it.addr;
            #1;
            check_val(it.tag, rd_data, it.exp);
            done++;
        end
    end

    // driver side
    task automatic expect_reg(input logic [4:0] a, input logic [63:0] e, input string tag);
        sb.push_back('{addr: a, exp: e, tag: tag});
        pushed++;
        wait (done == pushed);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_evt(input int idx, input logic [3:0] v);
        evt[idx*4 +: 4] = v;
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic prep(input int idx, input logic [63:0] cfg);
        reg_wr(5'(8 + idx), cfg);
        reg_wr(5'(idx), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        expect_reg(5'd0,  64'd0, "R1 gen0 value");
        expect_reg(5'd8,  64'd0, "R1 gen0 config");
        expect_reg(5'd24, 64'd0, "R1 overflow status");
        expect_reg(5'd25, 64'd0, "R1 config error status");
        tick();

        // R2: raw count mode, independent slices
        prep(0, 64'h7);
        prep(5, 64'h7);
        priv = 2'd0;
        set_evt(0, 4'd3);  set_evt(5, 4'd1); tick();
        set_evt(0, 4'd5);  tick();
        set_evt(0, 4'd15); tick();
        evt = '0;
        expect_reg(5'd0, 64'd23, "R2 gen0 raw sum");
        expect_reg(5'd5, 64'd3,  "R2 gen5 own slice");
        tick();

        // R3: privilege gating, user-only on gen1, kernel-only on gen2
        prep(1, 64'h3);
        prep(2, 64'h5);
        priv = 2'd0;
        set_evt(1, 4'd4); set_evt(2, 4'd4);
        tick(); tick();
        priv = 2'd2; tick();
        evt = '0; priv = 2'd0;
        expect_reg(5'd1, 64'd4, "R3 user-only gen1");
        expect_reg(5'd2, 64'd8, "R3 kernel-only gen2");
        tick();

        // R4 / R5: threshold 4, plain on gen0 and inverted on gen1
        prep(0, 64'h0407);
        prep(1, 64'h040F);
        begin
            logic [3:0] pat [4] = '{4'd3, 4'd4, 4'd9, 4'd2};
            for (int k = 0; k < 4; k++) begin
                set_evt(0, pat[k]); set_evt(1, pat[k]); tick();
            end
        end
        evt = '0;
        expect_reg(5'd0, 64'd2, "R4 threshold count");
        expect_reg(5'd1, 64'd2, "R5 inverted count");
        tick();

        // R6: edge mode threshold 2 on gen3
        prep(3, 64'h0217);
        begin
            logic [3:0] pat [7] = '{4'd0, 4'd3, 4'd3, 4'd0, 4'd5, 4'd1, 4'd2};
            for (int k = 0; k < 7; k++) begin
                set_evt(3, pat[k]); tick();
            end
        end
        evt = '0;
        expect_reg(5'd3, 64'd3, "R6 edge count");
        tick();

        // R7: edge with threshold 0
        prep(4, 64'h0017);
        set_evt(4, 4'd5);
        tick(); tick(); tick();
        evt = '0;
        expect_reg(5'd4,  64'd0,  "R7 no count");
        expect_reg(5'd25, 64'h10, "R7 error bit set");
        check_val("R7 cfg_err_o port", 64'(cfg_err), 64'h10);
        tick();
        reg_wr(5'd12, 64'd0);
        expect_reg(5'd25, 64'h10, "R7 error bit sticky");
        tick();
        reg_wr(5'd25, 64'h10);
        expect_reg(5'd25, 64'd0, "R7 error bit cleared");
        tick();

        // R8: write priority and config readback
        reg_wr(5'd8, 64'h7);
        set_evt(0, 4'd2);
        reg_wr(5'd0, 64'd1000);
        expect_reg(5'd0, 64'd1000, "R8 write wins");
        tick();
        evt = '0;
        expect_reg(5'd0, 64'd1002, "R8 counts after write");
        reg_wr(5'd9, 64'h0A1B);
        expect_reg(5'd9, 64'h0A1B, "R8 config readback");
        tick();

        // R9: wraparound and overflow status
        evt = '0;
        reg_wr(5'd0, 64'h0000_FFFF_FFFF_FFFE);
        set_evt(0, 4'd5); tick();
        evt = '0;
        expect_reg(5'd0,  64'd3, "R9 wrapped value");
        expect_reg(5'd24, 64'h1, "R9 overflow bit");
        check_val("R9 ovf_o port", 64'(ovf), 64'h1);
        tick();
        reg_wr(5'd24, 64'h1);
        expect_reg(5'd24, 64'h0, "R9 overflow cleared");
        tick();

        // R10: fixed counters
        reg_wr(5'd20, 64'h753);
        expect_reg(5'd20, 64'h753, "R10 fixed config readback");
        fevt = 3'b111; priv = 2'd0;
        tick(); tick();
        priv = 2'd3;
        tick(); tick(); tick();
        fevt = 3'b000;
        tick();
        expect_reg(5'd16, 64'd3, "R10 fixed0 user only");
        expect_reg(5'd17, 64'd2, "R10 fixed1 kernel only");
        expect_reg(5'd18, 64'd5, "R10 fixed2 both");
        tick();
        priv = 2'd0;

        // R11: edge state cleared on reconfiguration
        prep(2, 64'h0117);
        set_evt(2, 4'd3);
        tick(); tick();
        expect_reg(5'd2, 64'd1, "R11 single edge while held");
        reg_wr(5'd10, 64'd0);
        reg_wr(5'd10, 64'h0117);
        tick(); tick();
        evt = '0;
        expect_reg(5'd2, 64'd2, "R11 counts again after re-enable");
        tick();

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule